// File: doc/BRIEF.md
# Floating-point compare condition unit

This block executes one floating-point compare per accepted instruction. It takes a 32-bit compare instruction word and two 64-bit operands, which a neighbouring register file supplies after reading the two source indices that the block brings out. The block decodes whether the compare is single or double precision. It decodes whether the compare is quiet or signaling, and it decodes which relations should make the answer true. One shared classifier places the operand pair into exactly one relation: less, equal, greater or unordered. The block then tests that relation against the decoded mask.

The one-bit answer is written into one of eight condition flags. In the cycle after the instruction is sampled, the answer appears on a registered `done` pulse, together with an invalid-operation flag. An instruction word that is not a legal compare raises `illegal` in that same cycle and leaves every condition flag as it was.

Top module: `fcmp_cond_unit`

## Requirements
- R1: When `in_valid` is high, instruction bits 31:20 equal to 0x0C1 select a single-precision compare and 0x0C2 select a double-precision compare; a double compare uses all 64 operand bits.
- R2: `src_a_idx` is instruction bits 9:5 and `src_b_idx` is bits 14:10, both combinational; the condition field is bits 19:15 and the destination flag index is bits 2:0.
- R3: Condition field bit 1 enables less, bit 2 enables equal, bit 3 enables unordered, and bit 4 enables both less and greater; the result is 1 exactly when the enabled set contains the operands' relation, and it is written into the flag chosen by bits 2:0.
- R4: Ordered operands compare by sign and magnitude: for negative values the larger magnitude is the smaller number, and +0 equals -0.
- R5: If either operand is a NaN (exponent all ones, mantissa nonzero), the relation is unordered.
- R6: A single-precision compare uses only bits 31:0 of each operand; the upper halves have no effect on the result or on the invalid flag.
- R7: Condition bit 0 = 1 (signaling) raises `invalid_flag` when either operand is any NaN; bit 0 = 0 (quiet) raises it only for a signaling NaN, which is a NaN whose mantissa MSB is 0.
- R8: An instruction whose opcode matches neither value, or whose bits 4:3 are not 00, raises `illegal` with `done`, drives `result` and `invalid_flag` low, and leaves all condition flags unchanged.
- R9: `done`, `result`, `invalid_flag` and `illegal` update on the clock edge that samples `in_valid`. `done` is high for exactly one cycle per accepted instruction and is low otherwise, and a legal compare changes only the selected flag.
- R10: Synchronous active-high `rst` clears all eight condition flags and drives `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Compare instruction word |
| opnd_a | input | 64 | First source operand |
| opnd_b | input | 64 | Second source operand |
| src_a_idx | output | 5 | Decoded first source register index |
| src_b_idx | output | 5 | Decoded second source register index |
| done | output | 1 | One-cycle pulse marking a completed instruction |
| result | output | 1 | Compare answer written this cycle |
| invalid_flag | output | 1 | Invalid-operation exception for this compare |
| illegal | output | 1 | The instruction word was not a legal compare |
| cond_flags | output | 8 | Current contents of the condition flag file |

## Verification
The flag file is visible at the ports, so a write to the wrong entry shows up one cycle after the faulty instruction. It appears as a second changed bit, or as a changed bit that differs from the index the bench predicted. A wrong relation or a wrong mask decode appears on `result` in the cycle after the operands are sampled. A mistake in sNaN or signaling detection appears on `invalid_flag` in that same cycle. A corrupted decode of the illegal case also shows up one cycle later, as a flag that changes when it should not or as a missing `illegal` pulse.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int INSTR_W   = 32;
    localparam int OPND_W    = 64;
    localparam int REG_IDX_W = 5;
    localparam int COND_W    = 5;
    localparam int MAG_W     = OPND_W - 1;

    localparam logic [11:0] OPC_CMP_SP = 12'h0C1;
    localparam logic [11:0] OPC_CMP_DP = 12'h0C2;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic {
        PREC_SP = 1'b0,
        PREC_DP = 1'b1
    } prec_e;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic un;
    } rel_mask_t;

    typedef struct packed {
        logic      legal;
        prec_e     prec;
        logic      signaling;
        rel_mask_t mask;
    } cmp_dec_t;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } fp_view_t;

    function automatic fp_view_t view_sp(input logic [31:0] x);
        fp_view_t v;
        logic [7:0]  ex;
        logic [22:0] mt;
        ex     = x[30:23];
        mt     = x[22:0];
        v.sign = x[31];
        v.nan  = (&ex) && (|mt);
        v.snan = v.nan && !mt[22];
        v.zero = ~|x[30:0];
        v.mag  = {{(MAG_W-31){1'b0}}, x[30:0]};
        return v;
    endfunction

    function automatic fp_view_t view_dp(input logic [63:0] x);
        fp_view_t v;
        logic [10:0] ex;
        logic [51:0] mt;
        ex     = x[62:52];
        mt     = x[51:0];
        v.sign = x[63];
        v.nan  = (&ex) && (|mt);
        v.snan = v.nan && !mt[51];
        v.zero = ~|x[62:0];
        v.mag  = x[62:0];
        return v;
    endfunction

    function automatic rel_mask_t cond_to_mask(input logic [COND_W-1:0] c);
        rel_mask_t m;
        m.lt = c[1] | c[4];
        m.eq = c[2];
        m.gt = c[4];
        m.un = c[3];
        return m;
    endfunction

endpackage

// File: rtl/fcmp_decoder.sv
module fcmp_decoder
    import fcmp_pkg::*;
#(
    parameter int FLAG_IDX_W = 3
) (
    input  logic [INSTR_W-1:0]   instr,
    output cmp_dec_t             dec,
    output logic [FLAG_IDX_W-1:0] dst_idx,
    output logic [REG_IDX_W-1:0] src_a,
    output logic [REG_IDX_W-1:0] src_b
);
    logic [11:0]       opc;
    logic [COND_W-1:0] cond;
    logic              is_sp;
    logic              is_dp;

    always_comb begin
        opc   = instr[31:20];
        cond  = instr[19:15];
        is_sp = (opc == OPC_CMP_SP);
        is_dp = (opc == OPC_CMP_DP);

        dec.legal     = (is_sp || is_dp) && (instr[4:3] == 2'b00);
        dec.prec      = is_dp ? PREC_DP : PREC_SP;
        dec.signaling = cond[0];
        dec.mask      = cond_to_mask(cond);
    end

    assign src_a   = instr[9:5];
    assign src_b   = instr[14:10];
    assign dst_idx = instr[FLAG_IDX_W-1:0];

endmodule

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  prec_e             prec,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    output rel_e              rel,
    output logic              any_nan,
    output logic              any_snan
);
    localparam int NUM_OPS = 2;

    logic [OPND_W-1:0] raw [NUM_OPS];
    fp_view_t          vw  [NUM_OPS];

    assign raw[0] = opnd_a;
    assign raw[1] = opnd_b;

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_view
        always_comb begin
            if (prec == PREC_DP) vw[k] = view_dp(raw[k]);
            else                 vw[k] = view_sp(raw[k][31:0]);
        end
    end

    logic mag_lt;
    logic mag_eq;

    always_comb begin
        any_nan  = vw[0].nan  | vw[1].nan;
        any_snan = vw[0].snan | vw[1].snan;
        mag_lt   = vw[0].mag < vw[1].mag;
        mag_eq   = vw[0].mag == vw[1].mag;

        if (any_nan)                        rel = REL_UN;
        else if (vw[0].zero && vw[1].zero)  rel = REL_EQ;
        else if (vw[0].sign != vw[1].sign)  rel = vw[0].sign ? REL_LT : REL_GT;
        else if (mag_eq)                    rel = REL_EQ;
        else if (mag_lt ^ vw[0].sign)       rel = REL_LT;
        else                                rel = REL_GT;
    end

endmodule

// File: rtl/fcmp_flag_file.sv
module fcmp_flag_file #(
    parameter int FLAG_IDX_W = 3,
    localparam int NUM_FLAGS = 1 << FLAG_IDX_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [FLAG_IDX_W-1:0] wr_idx,
    input  logic                  wr_bit,
    output logic [NUM_FLAGS-1:0]  flags
);
    logic [NUM_FLAGS-1:0] sel;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sel
        assign sel[i] = wr_en && (wr_idx == FLAG_IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~sel) | (sel & {NUM_FLAGS{wr_bit}});
    end

endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
    import fcmp_pkg::*;
#(
    parameter int FLAG_IDX_W = 3,
    localparam int NUM_FLAGS = 1 << FLAG_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [OPND_W-1:0]    opnd_a,
    input  logic [OPND_W-1:0]    opnd_b,
    output logic [REG_IDX_W-1:0] src_a_idx,
    output logic [REG_IDX_W-1:0] src_b_idx,
    output logic                 done,
    output logic                 result,
    output logic                 invalid_flag,
    output logic                 illegal,
    output logic [NUM_FLAGS-1:0] cond_flags
);
    cmp_dec_t              dec;
    logic [FLAG_IDX_W-1:0] dst_idx;
    rel_e                  rel;
    logic                  any_nan;
    logic                  any_snan;
    logic                  hit;
    logic                  inv_raise;
    logic                  do_write;

    fcmp_decoder #(.FLAG_IDX_W(FLAG_IDX_W)) u_dec (
        .instr   (instr),
        .dec     (dec),
        .dst_idx (dst_idx),
        .src_a   (src_a_idx),
        .src_b   (src_b_idx)
    );

    fcmp_classify u_cls (
        .prec     (dec.prec),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .rel      (rel),
        .any_nan  (any_nan),
        .any_snan (any_snan)
    );

    always_comb begin
        unique case (rel)
            REL_LT:  hit = dec.mask.lt;
            REL_EQ:  hit = dec.mask.eq;
            REL_GT:  hit = dec.mask.gt;
            default: hit = dec.mask.un;
        endcase
        inv_raise = dec.signaling ? any_nan : any_snan;
        do_write  = in_valid && dec.legal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done         <= 1'b0;
            result       <= 1'b0;
            invalid_flag <= 1'b0;
            illegal      <= 1'b0;
        end else begin
            done         <= in_valid;
            result       <= do_write && hit;
            invalid_flag <= do_write && inv_raise;
            illegal      <= in_valid && !dec.legal;
        end
    end

    fcmp_flag_file #(.FLAG_IDX_W(FLAG_IDX_W)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (do_write),
        .wr_idx (dst_idx),
        .wr_bit (hit),
        .flags  (cond_flags)
    );

endmodule

// File: rtl/fcmp_cond_unit_chk.sv
module fcmp_cond_unit_chk
    import fcmp_pkg::*;
#(
    parameter int FLAG_IDX_W = 3,
    localparam int NUM_FLAGS = 1 << FLAG_IDX_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [INSTR_W-1:0]   instr,
    input logic                 done,
    input logic                 result,
    input logic                 invalid_flag,
    input logic                 illegal,
    input logic [NUM_FLAGS-1:0] cond_flags
);
    logic seen_rst = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
    end

    p_done_follows_r9: assert property (@(posedge clk) disable iff (rst)
        seen_rst && in_valid |=> done);

    p_no_spurious_done_r9: assert property (@(posedge clk) disable iff (rst)
        seen_rst && !in_valid |=> !done);

    p_illegal_keeps_flags_r8: assert property (@(posedge clk) disable iff (rst)
        seen_rst && done && illegal |-> cond_flags == $past(cond_flags));

    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        seen_rst && done && illegal |-> !result && !invalid_flag);

    p_write_target_r3: assert property (@(posedge clk) disable iff (rst)
        seen_rst && done && !illegal |->
            cond_flags[$past(instr[FLAG_IDX_W-1:0])] == result);

    p_single_change_r9: assert property (@(posedge clk) disable iff (rst)
        seen_rst && !$past(rst) |->
            $countones(cond_flags ^ $past(cond_flags)) <= 1);

    p_reset_clears_r10: assert property (@(posedge clk) disable iff (rst)
        seen_rst && $past(rst) |-> cond_flags == '0 && !done);

endmodule

bind fcmp_cond_unit fcmp_cond_unit_chk #(.FLAG_IDX_W(FLAG_IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .instr        (instr),
    .done         (done),
    .result       (result),
    .invalid_flag (invalid_flag),
    .illegal      (illegal),
    .cond_flags   (cond_flags)
);

// File: tb/sim_fcmp_cond_unit.sv
`timescale 1ns/1ps
module sim_fcmp_cond_unit;

    localparam logic [11:0] OP_S = 12'h0C1;
    localparam logic [11:0] OP_D = 12'h0C2;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] opnd_a, opnd_b;
    logic [4:0]  src_a_idx, src_b_idx;
    logic        done, result, invalid_flag, illegal;
    logic [7:0]  cond_flags;

    always #2 clk = ~clk;

    fcmp_cond_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .src_a_idx(src_a_idx),
        .src_b_idx(src_b_idx), .done(done), .result(result),
        .invalid_flag(invalid_flag), .illegal(illegal), .cond_flags(cond_flags)
    );

    typedef struct {
        logic       res;
        logic       inv;
        logic       ill;
        logic [7:0] flags;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         fails  = 0;
    logic [7:0] mflags = 8'h00;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [11:0] op, input logic [4:0] c,
                                       input logic [4:0] fa, input logic [4:0] fb,
                                       input logic [2:0] cd);
        return {op, c, fb, fa, 2'b00, cd};
    endfunction

    // independent model: NaN tests, then a monotone integer key per value
    function automatic bit m_nan(input bit dp, input logic [63:0] x);
        if (dp) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic bit m_snan(input bit dp, input logic [63:0] x);
        if (dp) return m_nan(1, x) && (x[51] == 1'b0);
        return m_nan(0, x) && (x[22] == 1'b0);
    endfunction

    function automatic logic [63:0] m_key(input bit dp, input logic [63:0] x);
        logic [62:0] body;
        bit          s;
        s    = dp ? x[63] : x[31];
        body = dp ? x[62:0] : {32'b0, x[30:0]};
        return s ? {1'b0, ~body} : {1'b1, body};
    endfunction

    // 0 less, 1 equal, 2 greater, 3 unordered
    function automatic int m_rel(input bit dp, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] ka, kb;
        if (m_nan(dp, a) || m_nan(dp, b)) return 3;
        if ((dp ? a[62:0] : {32'b0, a[30:0]}) == 0 &&
            (dp ? b[62:0] : {32'b0, b[30:0]}) == 0) return 1;
        ka = m_key(dp, a);
        kb = m_key(dp, b);
        if (ka < kb) return 0;
        if (ka == kb) return 1;
        return 2;
    endfunction

    task automatic issue(input string tag, input logic [31:0] w,
                         input logic [63:0] a, input logic [63:0] b);
        exp_t e;
        bit   legal, dp;
        int   r;
        logic [4:0] c;
        instr    = w;
        opnd_a   = a;
        opnd_b   = b;
        in_valid = 1'b1;
        legal = (w[31:20] == OP_S || w[31:20] == OP_D) && (w[4:3] == 2'b00);
        dp    = (w[31:20] == OP_D);
        c     = w[19:15];
        e.tag = tag;
        e.ill = !legal;
        if (legal) begin
            r = m_rel(dp, a, b);
            case (r)
                0: e.res = c[1] | c[4];
                1: e.res = c[2];
                2: e.res = c[4];
                default: e.res = c[3];
            endcase
            e.inv = c[0] ? (m_nan(dp, a) || m_nan(dp, b))
                         : (m_snan(dp, a) || m_snan(dp, b));
            mflags[w[2:0]] = e.res;
        end else begin
            e.res = 1'b0;
            e.inv = 1'b0;
        end
        e.flags = mflags;
        sb.push_back(e);
        #1;
        // R2: source index fields brought out combinationally
        chk("R2", "src_a_idx", 64'(src_a_idx), 64'(w[9:5]));
        chk("R2", "src_b_idx", 64'(src_b_idx), 64'(w[14:10]));
        @(negedge clk);
    endtask

    // monitor: pops one expected item for every done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                chk("R9", "done without instruction", 64'(done), 64'(0));
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "result", 64'(result), 64'(e.res));
                chk(e.tag, "invalid_flag", 64'(invalid_flag), 64'(e.inv));
                chk(e.tag, "illegal", 64'(illegal), 64'(e.ill));
                chk(e.tag, "cond_flags", 64'(cond_flags), 64'(e.flags));
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: flags cleared and no done after reset
        chk("R10", "cond_flags after reset", 64'(cond_flags), 64'(0));
        chk("R10", "done after reset", 64'(done), 64'(0));

        // single precision: R3 mask, R4 ordering
        issue("R3", mk(OP_S, 5'h02, 5'd1, 5'd2, 3'd0), 64'h3F800000, 64'h40000000);
        issue("R3", mk(OP_S, 5'h02, 5'd3, 5'd4, 3'd1), 64'h40000000, 64'h3F800000);
        issue("R4", mk(OP_S, 5'h02, 5'd5, 5'd6, 3'd2), 64'hC0000000, 64'hBF800000);
        issue("R4", mk(OP_S, 5'h04, 5'd7, 5'd8, 3'd3), 64'h00000000, 64'h80000000);
        issue("R4", mk(OP_S, 5'h02, 5'd9, 5'd10, 3'd7), 64'hBF800000, 64'h3F800000);
        issue("R4", mk(OP_S, 5'h02, 5'd11, 5'd12, 3'd7), 64'h80000000, 64'h00000000);
        // R5 / R7: NaN handling, quiet vs signaling
        issue("R5", mk(OP_S, 5'h08, 5'd13, 5'd14, 3'd4), 64'h7FC00000, 64'h3F800000);
        issue("R7", mk(OP_S, 5'h03, 5'd15, 5'd16, 3'd5), 64'h7FC00000, 64'h3F800000);
        issue("R7", mk(OP_S, 5'h04, 5'd17, 5'd18, 3'd6), 64'h3F800000, 64'h7FA00000);
        // R6: upper halves would be NaN/greater if used
        issue("R6", mk(OP_S, 5'h02, 5'd19, 5'd20, 3'd7),
              64'hFFFFFFFF_3F800000, 64'h12345678_40000000);
        issue("R6", mk(OP_S, 5'h04, 5'd21, 5'd22, 3'd1),
              64'h7FF40000_3F800000, 64'h00000000_3F800000);
        // double precision: R1 and R3 not-equal
        issue("R3", mk(OP_D, 5'h10, 5'd23, 5'd24, 3'd0),
              64'h3FF0000000000000, 64'h4000000000000000);
        issue("R3", mk(OP_D, 5'h10, 5'd25, 5'd26, 3'd1),
              64'h3FF0000000000000, 64'h3FF0000000000000);
        issue("R4", mk(OP_D, 5'h02, 5'd27, 5'd28, 3'd2),
              64'hBFF0000000000000, 64'hC000000000000000);
        issue("R5", mk(OP_D, 5'h10, 5'd29, 5'd30, 3'd3),
              64'h7FF8000000000000, 64'h3FF0000000000000);
        issue("R7", mk(OP_D, 5'h08, 5'd31, 5'd0, 3'd4),
              64'h3FF0000000000000, 64'h7FF4000000000000);
        issue("R3", mk(OP_D, 5'h06, 5'd2, 5'd1, 3'd5),
              64'h3FF0000000000000, 64'h3FF0000000000000);
        issue("R1", mk(OP_D, 5'h02, 5'd4, 5'd3, 3'd6),
              64'h3FF0000000000000, 64'h3FF0000000000001);
        // R8: illegal encodings keep every flag
        issue("R8", mk(12'h0C3, 5'h02, 5'd1, 5'd2, 3'd0),
              64'h3F800000, 64'h40000000);
        issue("R8", mk(OP_S, 5'h04, 5'd1, 5'd2, 3'd1) | 32'h8,
              64'h0, 64'h0);
        issue("R8", mk(OP_D, 5'h04, 5'd1, 5'd2, 3'd2) | 32'h10,
              64'h0, 64'h0);

        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        // R9: no pending results and done low when idle
        chk("R9", "unanswered instructions", 64'(sb.size()), 64'(0));
        chk("R9", "done while idle", 64'(done), 64'(0));
        chk("R8", "flags after illegal run", 64'(cond_flags), 64'(mflags));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule